// File: doc/BRIEF.md
# Dual-Issue In-Order Dispatch Unit

This block sits between instruction fetch and two execution units: one integer unit and one floating-point unit. It keeps decoded instruction tags in a six-entry shifting queue and sends up to two of them per cycle to the units. Each tag carries one type bit that says whether it is integer or floating-point. Only the two oldest entries may issue. Issue stays in program order: a younger entry never passes an older one that is held.

Each fetch delivers up to two tags. When the queue cannot take two more entries after this cycle's issue, the block raises a stall and ignores the fetch. A floating-point issue is held back in three cases:
- an external denormalization-hazard input is high;
- the internal hazard state machine is in its shadow state, which lasts a parameterised number of cycles after every floating-point issue;
- the completion queue lacks a free slot for it.

The hazard state machine has two states. `HZ_CLEAR` lets floating-point work issue. `HZ_SHADOW` blocks it. The transitions are:
- ARM: from `HZ_CLEAR` to `HZ_SHADOW` on a floating-point issue, with a down-counter loaded with `HZ_CYCLES`.
- HOLD: stays in `HZ_SHADOW` while the counter is above one, decrementing it each cycle.
- EXPIRE: returns to `HZ_CLEAR` when the counter reaches one.
- Reset forces `HZ_CLEAR`.

Top module: `dual_dispatch`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) empties the queue and returns the hazard machine to `HZ_CLEAR`. After reset, both issue strobes and `fetch_stall` are low until new tags arrive.
- R2: Only queue positions 0 (oldest) and 1 are issue candidates. Position 1 issues only in a cycle in which position 0 also issues.
- R3: At most one integer and one floating-point tag issue per cycle. Two same-type tags at the bottom of the queue issue in successive cycles.
- R4: A floating-point tag does not issue while `fp_denorm_hz` is high. It also does not issue during the `HZ_CYCLES` cycles (default 2) that follow any floating-point issue, even when `fp_ready` is high.
- R5: No tag issues when `cq_free` is 0. Two tags issue together only when `cq_free` is at least 2.
- R6: `fetch_stall` is high exactly when the free queue space after this cycle's issues is below two. While it is high, the fetch port is ignored.
- R7: Of an accepted fetch, slot 0 (`fetch_vld[0]`) is older than slot 1. Valid slots are appended behind the existing entries in that order, and an invalid slot 0 leaves no gap.
- R8: An integer tag issues only with `int_ready` high. A floating-point tag issues only with `fp_ready` high.
- R9: `int_tag` and `fp_tag` carry the tag of the entry being issued while the matching strobe is high. Entries above the issued ones move down in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fetch_vld | input | 2 | Per-slot fetch valid; bit 0 is the older slot |
| fetch_fp | input | 2 | Per-slot type: 1 floating-point, 0 integer |
| fetch_tag0 | input | TAG_W | Tag of fetch slot 0 |
| fetch_tag1 | input | TAG_W | Tag of fetch slot 1 |
| int_ready | input | 1 | Integer unit can accept a tag |
| fp_ready | input | 1 | Floating-point unit first stage can accept a tag |
| cq_free | input | CQ_W | Free completion-queue slots |
| fp_denorm_hz | input | 1 | External denormalization hazard; blocks FP issue |
| int_issue | output | 1 | Integer issue strobe |
| int_tag | output | TAG_W | Tag issued to the integer unit |
| fp_issue | output | 1 | Floating-point issue strobe |
| fp_tag | output | TAG_W | Tag issued to the floating-point unit |
| fetch_stall | output | 1 | Fetch refused this cycle |

## Verification
The hardest case is a held floating-point tag at position 0 with a ready integer tag directly above it. Here the in-order rule alone must keep the integer unit idle. The stimulus reaches this state by issuing one floating-point tag and then fetching integers behind the second one. It then holds the blocked state for several cycles, first through the shadow window, then through the external hazard input, then through a completion-queue limit of one. The full-queue case takes a similar path: the integer unit is held off while fetches fill all six entries, so that the stall can be seen both with and without a same-cycle issue freeing space.

// File: rtl/dd_pkg.sv
package dd_pkg;
    typedef enum logic {
        HZ_CLEAR  = 1'b0,
        HZ_SHADOW = 1'b1
    } hz_state_e;
endpackage

// File: rtl/dd_iq.sv
module dd_iq #(
    parameter int DEPTH = 6,
    parameter int TAG_W = 4,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       n_issue,
    input  logic             accept,
    input  logic [1:0]       push_vld,
    input  logic [1:0]       push_fp,
    input  logic [TAG_W-1:0] push_tag0,
    input  logic [TAG_W-1:0] push_tag1,
    output logic             q0_vld,
    output logic             q0_fp,
    output logic [TAG_W-1:0] q0_tag,
    output logic             q1_vld,
    output logic             q1_fp,
    output logic [TAG_W-1:0] q1_tag,
    output logic [CNT_W-1:0] count
);
    logic [DEPTH-1:0] fp_q, fp_d;
    logic [TAG_W-1:0] tag_q [DEPTH];
    logic [TAG_W-1:0] tag_d [DEPTH];
    logic [CNT_W-1:0] count_q, count_d, base, pos1;

    always_comb begin
        base = count_q - CNT_W'(n_issue);
        pos1 = base + CNT_W'(push_vld[0]);
        for (int i = 0; i < DEPTH; i++) begin
            int src;
            src = i + int'(n_issue);
            if (src < DEPTH) begin
                fp_d[i]  = fp_q[src];
                tag_d[i] = tag_q[src];
            end else begin
                fp_d[i]  = 1'b0;
                tag_d[i] = '0;
            end
            if (accept && push_vld[0] && CNT_W'(i) == base) begin
                fp_d[i]  = push_fp[0];
                tag_d[i] = push_tag0;
            end
            if (accept && push_vld[1] && CNT_W'(i) == pos1) begin
                fp_d[i]  = push_fp[1];
                tag_d[i] = push_tag1;
            end
        end
        count_d = base;
        if (accept) begin
            count_d = base + CNT_W'(push_vld[0]) + CNT_W'(push_vld[1]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
            fp_q    <= '0;
            for (int i = 0; i < DEPTH; i++) tag_q[i] <= '0;
        end else begin
            count_q <= count_d;
            fp_q    <= fp_d;
            for (int i = 0; i < DEPTH; i++) tag_q[i] <= tag_d[i];
        end
    end

    assign q0_vld = (count_q != '0);
    assign q1_vld = (count_q > CNT_W'(1));
    assign q0_fp  = fp_q[0];
    assign q1_fp  = fp_q[1];
    assign q0_tag = tag_q[0];
    assign q1_tag = tag_q[1];
    assign count  = count_q;
endmodule

// File: rtl/dd_hazard_fsm.sv
module dd_hazard_fsm
    import dd_pkg::*;
#(
    parameter int HZ_CYCLES = 2,
    localparam int HC_W = $clog2(HZ_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic fp_fired,
    output logic shadow
);
    hz_state_e       state_q, state_d;
    logic [HC_W-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= HZ_CLEAR;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            HZ_CLEAR: begin
                if (fp_fired) begin
                    state_d = HZ_SHADOW;
                    cnt_d   = HC_W'(HZ_CYCLES);
                end
            end
            HZ_SHADOW: begin
                if (fp_fired) begin
                    cnt_d = HC_W'(HZ_CYCLES);
                end else if (cnt_q <= HC_W'(1)) begin
                    state_d = HZ_CLEAR;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q - HC_W'(1);
                end
            end
            default: begin
                state_d = HZ_CLEAR;
                cnt_d   = '0;
            end
        endcase
    end

    always_comb begin
        unique case (state_q)
            HZ_SHADOW: shadow = 1'b1;
            default:   shadow = 1'b0;
        endcase
    end
endmodule

// File: rtl/dd_issue_sel.sv
module dd_issue_sel #(
    parameter int TAG_W = 4,
    parameter int CQ_W  = 3
) (
    input  logic             q0_vld,
    input  logic             q0_fp,
    input  logic [TAG_W-1:0] q0_tag,
    input  logic             q1_vld,
    input  logic             q1_fp,
    input  logic [TAG_W-1:0] q1_tag,
    input  logic             int_ready,
    input  logic             fp_ready,
    input  logic             fp_block,
    input  logic [CQ_W-1:0]  cq_free,
    output logic             int_issue,
    output logic [TAG_W-1:0] int_tag,
    output logic             fp_issue,
    output logic [TAG_W-1:0] fp_tag,
    output logic [1:0]       n_issue
);
    logic fp_go, ok0, ok1;

    always_comb begin
        fp_go = fp_ready && !fp_block;
        ok0 = q0_vld && (cq_free != '0) && (q0_fp ? fp_go : int_ready);
        ok1 = ok0 && q1_vld && (q1_fp != q0_fp) && (cq_free >= CQ_W'(2))
              && (q1_fp ? fp_go : int_ready);

        int_issue = (ok0 && !q0_fp) || (ok1 && !q1_fp);
        fp_issue  = (ok0 && q0_fp) || (ok1 && q1_fp);
        int_tag   = (ok0 && !q0_fp) ? q0_tag : (ok1 && !q1_fp) ? q1_tag : '0;
        fp_tag    = (ok0 && q0_fp) ? q0_tag : (ok1 && q1_fp) ? q1_tag : '0;
        n_issue   = {1'b0, ok0} + {1'b0, ok1};
    end
endmodule

// File: rtl/dual_dispatch.sv
module dual_dispatch #(
    parameter int DEPTH     = 6,
    parameter int TAG_W     = 4,
    parameter int CQ_W      = 3,
    parameter int HZ_CYCLES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       fetch_vld,
    input  logic [1:0]       fetch_fp,
    input  logic [TAG_W-1:0] fetch_tag0,
    input  logic [TAG_W-1:0] fetch_tag1,
    input  logic             int_ready,
    input  logic             fp_ready,
    input  logic [CQ_W-1:0]  cq_free,
    input  logic             fp_denorm_hz,
    output logic             int_issue,
    output logic [TAG_W-1:0] int_tag,
    output logic             fp_issue,
    output logic [TAG_W-1:0] fp_tag,
    output logic             fetch_stall
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic             q0_vld, q0_fp, q1_vld, q1_fp;
    logic [TAG_W-1:0] q0_tag, q1_tag;
    logic [CNT_W-1:0] iq_count;
    logic [1:0]       n_issue;
    logic             shadow;
    logic [CNT_W:0]   free_after;

    dd_iq #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_iq (
        .clk(clk), .rst(rst), .n_issue(n_issue), .accept(!fetch_stall),
        .push_vld(fetch_vld), .push_fp(fetch_fp),
        .push_tag0(fetch_tag0), .push_tag1(fetch_tag1),
        .q0_vld(q0_vld), .q0_fp(q0_fp), .q0_tag(q0_tag),
        .q1_vld(q1_vld), .q1_fp(q1_fp), .q1_tag(q1_tag),
        .count(iq_count)
    );

    dd_hazard_fsm #(.HZ_CYCLES(HZ_CYCLES)) u_hz (
        .clk(clk), .rst(rst), .fp_fired(fp_issue), .shadow(shadow)
    );

    dd_issue_sel #(.TAG_W(TAG_W), .CQ_W(CQ_W)) u_sel (
        .q0_vld(q0_vld), .q0_fp(q0_fp), .q0_tag(q0_tag),
        .q1_vld(q1_vld), .q1_fp(q1_fp), .q1_tag(q1_tag),
        .int_ready(int_ready), .fp_ready(fp_ready),
        .fp_block(shadow || fp_denorm_hz), .cq_free(cq_free),
        .int_issue(int_issue), .int_tag(int_tag),
        .fp_issue(fp_issue), .fp_tag(fp_tag), .n_issue(n_issue)
    );

    assign free_after  = (CNT_W+1)'(DEPTH) - {1'b0, iq_count} + (CNT_W+1)'(n_issue);
    assign fetch_stall = free_after < (CNT_W+1)'(2);
endmodule

// File: rtl/dual_dispatch_chk.sv
module dual_dispatch_chk #(
    parameter int DEPTH = 6,
    parameter int CQ_W  = 3,
    parameter int CNT_W = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             int_ready,
    input logic             fp_ready,
    input logic [CQ_W-1:0]  cq_free,
    input logic             fp_denorm_hz,
    input logic             int_issue,
    input logic             fp_issue,
    input logic             fetch_stall,
    input logic [CNT_W-1:0] iq_count
);
    assert_rst_quiet_R1: assert property (@(posedge clk)
        $past(rst) |-> (!int_issue && !fp_issue && !fetch_stall));

    assert_int_ready_R8: assert property (@(posedge clk) disable iff (rst)
        int_issue |-> int_ready);

    assert_fp_ready_R8: assert property (@(posedge clk) disable iff (rst)
        fp_issue |-> fp_ready);

    assert_cq_any_R5: assert property (@(posedge clk) disable iff (rst)
        (int_issue || fp_issue) |-> (cq_free != '0));

    assert_cq_pair_R5: assert property (@(posedge clk) disable iff (rst)
        (int_issue && fp_issue) |-> (cq_free >= CQ_W'(2)));

    assert_ext_hz_R4: assert property (@(posedge clk) disable iff (rst)
        fp_issue |-> !fp_denorm_hz);

    assert_shadow_R4: assert property (@(posedge clk) disable iff (rst)
        fp_issue |=> !fp_issue);

    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (rst)
        iq_count <= CNT_W'(DEPTH));

    assert_full_stall_R6: assert property (@(posedge clk) disable iff (rst)
        (iq_count == CNT_W'(DEPTH) && !int_issue && !fp_issue) |-> fetch_stall);
endmodule

bind dual_dispatch dual_dispatch_chk #(.DEPTH(DEPTH), .CQ_W(CQ_W), .CNT_W(CNT_W)) chk_i (
    .clk(clk), .rst(rst), .int_ready(int_ready), .fp_ready(fp_ready),
    .cq_free(cq_free), .fp_denorm_hz(fp_denorm_hz), .int_issue(int_issue),
    .fp_issue(fp_issue), .fetch_stall(fetch_stall), .iq_count(iq_count)
);

// File: tb/dual_dispatch_tb_top.sv
`timescale 1ns/1ps
module dual_dispatch_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] fetch_vld = '0, fetch_fp = '0;
    logic [3:0] fetch_tag0 = '0, fetch_tag1 = '0;
    logic       int_ready = 1'b0, fp_ready = 1'b0, fp_denorm_hz = 1'b0;
    logic [2:0] cq_free = '0;
    logic       int_issue, fp_issue, fetch_stall;
    logic [3:0] int_tag, fp_tag;

    int n_run = 0, n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    dual_dispatch dut_i (
        .clk(clk), .rst(rst), .fetch_vld(fetch_vld), .fetch_fp(fetch_fp),
        .fetch_tag0(fetch_tag0), .fetch_tag1(fetch_tag1),
        .int_ready(int_ready), .fp_ready(fp_ready), .cq_free(cq_free),
        .fp_denorm_hz(fp_denorm_hz), .int_issue(int_issue), .int_tag(int_tag),
        .fp_issue(fp_issue), .fp_tag(fp_tag), .fetch_stall(fetch_stall)
    );

    typedef struct packed {
        logic [1:0]  fv;
        logic [1:0]  ffp;
        logic [3:0]  t0;
        logic [3:0]  t1;
        logic        ir;
        logic        fr;
        logic [2:0]  cq;
        logic        hz;
        logic        ei;
        logic [3:0]  eit;
        logic        ef;
        logic [3:0]  eft;
        logic        est;
        logic [23:0] req;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VEC [NV] = '{
        // fv    ffp    t0 t1 ir fr cq hz  ei it ef ft st  req
        '{2'b11, 2'b00, 1, 2, 1, 1, 7, 0,  0, 0, 0, 0, 0, "R7 "}, // empty queue
        '{2'b11, 2'b01, 3, 4, 1, 1, 7, 0,  1, 1, 0, 0, 0, "R3 "}, // two ints at bottom
        '{2'b00, 2'b00, 0, 0, 1, 1, 7, 0,  1, 2, 1, 3, 0, "R9 "}, // pair issue
        '{2'b11, 2'b11, 5, 6, 1, 1, 7, 0,  1, 4, 0, 0, 0, "R9 "},
        '{2'b00, 2'b00, 0, 0, 1, 1, 7, 0,  0, 0, 0, 0, 0, "R4 "}, // shadow 2nd cycle
        '{2'b00, 2'b00, 0, 0, 1, 1, 7, 0,  0, 0, 1, 5, 0, "R3 "}, // one FP only
        '{2'b11, 2'b00, 7, 8, 1, 1, 7, 0,  0, 0, 0, 0, 0, "R4 "}, // shadow
        '{2'b00, 2'b00, 0, 0, 1, 1, 7, 0,  0, 0, 0, 0, 0, "R2 "}, // I7 held behind F6
        '{2'b00, 2'b00, 0, 0, 1, 1, 7, 1,  0, 0, 0, 0, 0, "R4 "}, // external hazard
        '{2'b00, 2'b00, 0, 0, 1, 1, 1, 0,  0, 0, 1, 6, 0, "R5 "}, // one CQ slot
        '{2'b11, 2'b00, 9,10, 1, 1, 0, 0,  0, 0, 0, 0, 0, "R5 "}, // no CQ slot
        '{2'b11, 2'b00,11,12, 0, 1, 7, 0,  0, 0, 0, 0, 0, "R8 "}, // int unit busy
        '{2'b11, 2'b00,13,14, 0, 1, 7, 0,  0, 0, 0, 0, 1, "R6 "}, // full, refused
        '{2'b11, 2'b00,13,14, 1, 1, 7, 0,  1, 7, 0, 0, 1, "R6 "}, // one freed
        '{2'b00, 2'b00, 0, 0, 1, 1, 7, 0,  1, 8, 0, 0, 0, "R6 "}, // two freed
        '{2'b11, 2'b01,13,14, 1, 1, 7, 0,  1, 9, 0, 0, 0, "R6 "},
        '{2'b00, 2'b00, 0, 0, 1, 1, 7, 0,  1,10, 0, 0, 0, "R6 "}, // refused tags absent
        '{2'b00, 2'b00, 0, 0, 1, 1, 7, 0,  1,11, 0, 0, 0, "R3 "},
        '{2'b00, 2'b00, 0, 0, 1, 0, 7, 0,  1,12, 0, 0, 0, "R8 "}, // FPU busy
        '{2'b00, 2'b00, 0, 0, 1, 1, 7, 0,  1,14, 1,13, 0, "R2 "}, // FP then int pair
        '{2'b10, 2'b00, 0,15, 1, 1, 7, 0,  0, 0, 0, 0, 0, "R7 "}, // slot 1 only
        '{2'b00, 2'b00, 0, 0, 1, 1, 7, 0,  1,15, 0, 0, 0, "R7 "}  // compacted
    };

    task automatic check(input string req, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        fetch_vld = v.fv; fetch_fp = v.ffp; fetch_tag0 = v.t0; fetch_tag1 = v.t1;
        int_ready = v.ir; fp_ready = v.fr; cq_free = v.cq; fp_denorm_hz = v.hz;
    endtask

    task automatic idle();
        fetch_vld = '0; fetch_fp = '0; fetch_tag0 = '0; fetch_tag1 = '0;
        int_ready = 1'b1; fp_ready = 1'b1; cq_free = 3'd7; fp_denorm_hz = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        idle();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        check("R1", "int_issue after reset", 8'(int_issue), 8'd0);
        check("R1", "fp_issue after reset", 8'(fp_issue), 8'd0);
        check("R1", "fetch_stall after reset", 8'(fetch_stall), 8'd0);

        for (int k = 0; k < NV; k++) begin
            string rq;
            @(negedge clk);
            drive(VEC[k]);
            #1;
            rq = $sformatf("%s(row %0d)", VEC[k].req, k);
            check(rq, "int_issue", 8'(int_issue), 8'(VEC[k].ei));
            check(rq, "fp_issue", 8'(fp_issue), 8'(VEC[k].ef));
            check(rq, "fetch_stall", 8'(fetch_stall), 8'(VEC[k].est));
            if (VEC[k].ei) check(rq, "int_tag", 8'(int_tag), 8'(VEC[k].eit));
            if (VEC[k].ef) check(rq, "fp_tag", 8'(fp_tag), 8'(VEC[k].eft));
        end

        // R1: reset while the queue holds tags
        @(negedge clk);
        idle(); int_ready = 1'b0;
        fetch_vld = 2'b11; fetch_tag0 = 4'd3; fetch_tag1 = 4'd4;
        @(negedge clk);
        fetch_tag0 = 4'd5; fetch_tag1 = 4'd6;
        @(negedge clk);
        idle(); rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #1;
        check("R1", "int_issue after mid-run reset", 8'(int_issue), 8'd0);
        check("R1", "fetch_stall after mid-run reset", 8'(fetch_stall), 8'd0);
        @(negedge clk);
        #1;
        check("R1", "queue stays empty", 8'(int_issue), 8'd0);

        // R6: single-tag fetch into five occupied entries is refused
        @(negedge clk);
        int_ready = 1'b0; fetch_vld = 2'b11; fetch_tag0 = 4'd1; fetch_tag1 = 4'd2;
        @(negedge clk);
        fetch_tag0 = 4'd3; fetch_tag1 = 4'd4;
        @(negedge clk);
        fetch_vld = 2'b01; fetch_tag0 = 4'd5;
        @(negedge clk);
        fetch_vld = 2'b01; fetch_tag0 = 4'd6;
        #1;
        check("R6", "stall with one free entry", 8'(fetch_stall), 8'd1);
        @(negedge clk);
        idle();
        for (int j = 1; j <= 5; j++) begin
            #1;
            check("R6", "drain order", 8'(int_tag), 8'(j));
            @(negedge clk);
        end
        #1;
        check("R6", "refused tag not queued", 8'(int_issue), 8'd0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule